// File: doc/BRIEF.md
# DMA Linked-List Descriptor Loader

The loader sits inside one DMA channel and keeps that channel's register set: two transfer-configuration words, a block-count word, a source address, a destination address and a link register. When the data engine reports that a block transfer has finished, the loader checks the link register. If the link register is all zero, the channel transfer is complete. Otherwise the loader fetches a descriptor from memory, one 32-bit word per register whose update bit is set, and then tells the engine to start the next block.

The link register holds a word-aligned 16-bit offset and six update-enable bits. The descriptor address is the 16-bit upper base value from a separate input joined with that offset. Registers whose bit is clear keep their value. When the block-count word is not reloaded, its low 16 bits are restored from a shadow of the last programmed count before the fetch begins. A memory error response stops the fetch and sets a sticky error flag.

Top module: `ll_desc_loader`

## Requirements
- R1: After a synchronous active-low reset, all six register outputs are zero and `mem_req`, `next_start`, `chan_done`, `link_err` and `link_busy` are low.
- R2: If `link_q` is all zero when `xfer_done` is sampled, `chan_done` is high for exactly the next cycle. No memory read is issued and no register changes.
- R3: Descriptor reads use the address `{base_hi, offset}` with bits [1:0] forced to zero. Each further word is at the previous address plus 4. `mem_addr` is held stable while `mem_req` waits for `mem_rvalid`.
- R4: Words are consumed in this fixed order of register index: 0 xcfg1, 1 xcfg2, 2 blk, 3 src, 4 dst, 5 link. Only registers whose enable bit is set take a word.
- R5: A register whose enable bit is clear keeps its value through the link transfer.
- R6: If the block-count enable bit (bit 18) is clear and the link register is nonzero, `blk_q[15:0]` is set back to the last count written through `cfg_we` or loaded from memory. This happens on the `xfer_done` edge, before any descriptor read. The data engine's own `eng_cnt` writes do not change this value.
- R7: The link register format is: offset in [15:2], [1:0] always zero, enable bits xcfg1..link in bits 16..21, and [31:22] always zero. The format applies both to `cfg_we` writes and to descriptor loads.
- R8: `next_start` is high for one cycle after the response to the last enabled word. If the link word just loaded is all zero, the next `xfer_done` raises `chan_done` instead of starting a fetch.
- R9: A read response with `mem_rerr` high ends the link transfer. The word is not written, no later register is updated, `next_start` stays low, and `link_err` goes high. `link_err` stays high until the next `cfg_we` write.
- R10: With no enable bit set but a nonzero offset, `next_start` pulses in the cycle after `xfer_done`, and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_hi | input | 16 | Upper 16 bits of the descriptor address |
| cfg_we | input | 1 | Programming write strobe |
| cfg_idx | input | 3 | Register index for the write (0..5) |
| cfg_wdata | input | 32 | Programming write data |
| eng_cnt_we | input | 1 | Data engine updates the live block count |
| eng_cnt | input | 16 | Live block count from the data engine |
| xfer_done | input | 1 | Current block transfer finished |
| mem_req | output | 1 | Descriptor read request, held until response |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rerr | input | 1 | Read response carries an error |
| mem_rdata | input | 32 | Read response data |
| xcfg1_q | output | 32 | Transfer configuration word 1 |
| xcfg2_q | output | 32 | Transfer configuration word 2 |
| blk_q | output | 32 | Block-count word (count in [15:0]) |
| src_q | output | 32 | Source address |
| dst_q | output | 32 | Destination address |
| link_q | output | 32 | Link register |
| next_start | output | 1 | Pulse: start the next block |
| chan_done | output | 1 | Pulse: channel transfer complete |
| link_err | output | 1 | Sticky descriptor read error |
| link_busy | output | 1 | Descriptor fetch in progress |

## Verification
The bench aims at the selective fetch. It uses a sparse mask whose consumed words must land at consecutive addresses. A loader that reserved a slot per register would read from gaps, and one that wrote unmasked registers would corrupt the config words. The count restore is tested after the engine has overwritten the count: a design that skipped the restore, or restored from the live value, would leave zero in the count. An error injected on the third word must leave the third word and every later word untouched and suppress `next_start`. A loaded all-zero link must end the list on the next completion, and an offset-only link must restart with no reads.

// File: rtl/ll_pkg.sv
// Shared constants and types for the descriptor loader.
// Assumes six registers in a fixed index order; the index order is also the
// descriptor word order.
package ll_pkg;
    localparam int NREG     = 6;
    localparam int IDX_W    = 3;
    localparam int IX_CFG1  = 0;
    localparam int IX_CFG2  = 1;
    localparam int IX_CNT   = 2;
    localparam int IX_SRC   = 3;
    localparam int IX_DST   = 4;
    localparam int IX_LINK  = 5;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } seq_st_e;
endpackage

// File: rtl/ll_link_decode.sv
// Splits the link register into its update-enable mask and offset, and flags
// the end-of-list condition. Assumes the enable bits sit directly above the
// offset field and that reserved bits always read as zero.
module ll_link_decode #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [DATA_W-1:0]       link_i,
    output logic [ll_pkg::NREG-1:0] en_mask_o,
    output logic [OFS_W-1:0]        ofs_o,
    output logic                    last_o
);
    localparam int EN_LSB = OFS_W;

    // Field extraction and end-of-list detection.
    always_comb begin
        en_mask_o = link_i[EN_LSB +: ll_pkg::NREG];
        ofs_o     = link_i[OFS_W-1:0];
        last_o    = (link_i == '0);
    end
endmodule

// File: rtl/ll_regfile.sv
// Holds the channel register set and the block-count shadow.
// Write priority, lowest to highest: engine count update, programming write,
// count restore, descriptor load. The link register is always stored in its
// legal format (offset word aligned, reserved bits zero).
module ll_regfile #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ll_pkg::IDX_W-1:0] cfg_idx,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic                     eng_cnt_we,
    input  logic [CNT_W-1:0]         eng_cnt,
    input  logic                     restore,
    input  logic                     ld_we,
    input  logic [ll_pkg::IDX_W-1:0] ld_idx,
    input  logic [DATA_W-1:0]        ld_data,
    output logic [DATA_W-1:0]        regs_o [ll_pkg::NREG]
);
    import ll_pkg::*;

    localparam int EN_LSB = OFS_W;
    localparam logic [DATA_W-1:0] LINK_KEEP =
        ((DATA_W'(1) << (EN_LSB + NREG)) - DATA_W'(1)) & ~DATA_W'(3);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [CNT_W-1:0]  shadow_q;

    // Shadow of the programmed block count, used by the restore step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (ld_we && ld_idx == IDX_W'(IX_CNT)) begin
            shadow_q <= ld_data[CNT_W-1:0];
        end else if (cfg_we && cfg_idx == IDX_W'(IX_CNT)) begin
            shadow_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [DATA_W-1:0] nxt;

        // Next value of register gi from its prioritized write sources.
        always_comb begin
            nxt = regs_q[gi];
            if (gi == IX_CNT) begin
                if (eng_cnt_we) nxt[CNT_W-1:0] = eng_cnt;
            end
            if (cfg_we && cfg_idx == IDX_W'(gi)) nxt = cfg_wdata;
            if (gi == IX_CNT) begin
                if (restore) nxt[CNT_W-1:0] = shadow_q;
            end
            if (ld_we && ld_idx == IDX_W'(gi)) nxt = ld_data;
            if (gi == IX_LINK) nxt = nxt & LINK_KEEP;
        end

        // Storage for register gi.
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[gi] <= '0;
            else        regs_q[gi] <= nxt;
        end

        assign regs_o[gi] = regs_q[gi];
    end
endmodule

// File: rtl/ll_fetch_seq.sv
// Link-transfer sequencer. On a transfer-done with a nonzero link register it
// snapshots the enable mask and descriptor address, then reads one word per set
// bit, lowest index first, at consecutive word addresses. One read is in flight
// at a time; mem_req is held until mem_rvalid. An error response stops the
// sequence. Transfer-done is ignored while a fetch is running.
module ll_fetch_seq #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    parameter int HI_W   = 16,
    localparam int ADDR_W = HI_W + OFS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer_done,
    input  logic                     err_clr,
    input  logic [ll_pkg::NREG-1:0]  en_mask,
    input  logic [OFS_W-1:0]         ofs,
    input  logic                     last,
    input  logic [HI_W-1:0]          base_hi,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_rvalid,
    input  logic                     mem_rerr,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     ld_we,
    output logic [ll_pkg::IDX_W-1:0] ld_idx,
    output logic [DATA_W-1:0]        ld_data,
    output logic                     restore,
    output logic                     next_start,
    output logic                     chan_done,
    output logic                     link_err,
    output logic                     busy
);
    import ll_pkg::*;

    seq_st_e           state_q;
    logic [NREG-1:0]   pend_q;
    logic [NREG-1:0]   rest_mask;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  cur_idx;
    logic              found;
    logic              start_link;
    logic              accept;
    logic              start_q;
    logic              done_q;
    logic              err_q;

    // Lowest pending register index and the mask left once it is served.
    always_comb begin
        cur_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (pend_q[i] && !found) begin
                cur_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
        rest_mask = pend_q & (pend_q - NREG'(1));
    end

    // Handshake decode, load strobe and count-restore request.
    always_comb begin
        start_link = (state_q == ST_IDLE) && xfer_done && !last;
        restore    = start_link && !en_mask[IX_CNT];
        accept     = (state_q == ST_FETCH) && mem_rvalid;
        ld_we      = accept && !mem_rerr;
        ld_idx     = cur_idx;
        ld_data    = mem_rdata;
        mem_req    = (state_q == ST_FETCH);
        mem_addr   = addr_q;
    end

    // Sequencer state, pending mask, address counter and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            start_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            if (err_clr) err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (xfer_done) begin
                        if (last) begin
                            done_q <= 1'b1;
                        end else begin
                            pend_q <= en_mask;
                            addr_q <= {base_hi, ofs} & ~ADDR_W'(3);
                            if (en_mask == '0) start_q <= 1'b1;
                            else               state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (accept) begin
                        if (mem_rerr) begin
                            err_q   <= 1'b1;
                            pend_q  <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            pend_q <= rest_mask;
                            addr_q <= addr_q + ADDR_W'(4);
                            if (rest_mask == '0) begin
                                start_q <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign next_start = start_q;
    assign chan_done  = done_q;
    assign link_err   = err_q;
    assign busy       = (state_q == ST_FETCH);
endmodule

// File: rtl/ll_desc_loader.sv
// Top of the linked-list descriptor loader for one DMA channel. Connects the
// register set, the link decoder and the fetch sequencer. Assumes the data
// engine raises xfer_done for one cycle per finished block and waits for
// next_start before the next block.
module ll_desc_loader #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    parameter int HI_W   = 16,
    parameter int CNT_W  = 16,
    localparam int ADDR_W = HI_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   base_hi,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              eng_cnt_we,
    input  logic [CNT_W-1:0]  eng_cnt,
    input  logic              xfer_done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] xcfg1_q,
    output logic [DATA_W-1:0] xcfg2_q,
    output logic [DATA_W-1:0] blk_q,
    output logic [DATA_W-1:0] src_q,
    output logic [DATA_W-1:0] dst_q,
    output logic [DATA_W-1:0] link_q,
    output logic              next_start,
    output logic              chan_done,
    output logic              link_err,
    output logic              link_busy
);
    import ll_pkg::*;

    logic [DATA_W-1:0] regs [NREG];
    logic [NREG-1:0]   en_mask;
    logic [OFS_W-1:0]  ofs;
    logic              last;
    logic              ld_we;
    logic [IDX_W-1:0]  ld_idx;
    logic [DATA_W-1:0] ld_data;
    logic              restore;

    ll_regfile #(.DATA_W(DATA_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .eng_cnt_we (eng_cnt_we),
        .eng_cnt    (eng_cnt),
        .restore    (restore),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .regs_o     (regs)
    );

    ll_link_decode #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_dec (
        .link_i    (regs[IX_LINK]),
        .en_mask_o (en_mask),
        .ofs_o     (ofs),
        .last_o    (last)
    );

    ll_fetch_seq #(.DATA_W(DATA_W), .OFS_W(OFS_W), .HI_W(HI_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_done  (xfer_done),
        .err_clr    (cfg_we),
        .en_mask    (en_mask),
        .ofs        (ofs),
        .last       (last),
        .base_hi    (base_hi),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .mem_rdata  (mem_rdata),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .restore    (restore),
        .next_start (next_start),
        .chan_done  (chan_done),
        .link_err   (link_err),
        .busy       (link_busy)
    );

    assign xcfg1_q = regs[IX_CFG1];
    assign xcfg2_q = regs[IX_CFG2];
    assign blk_q   = regs[IX_CNT];
    assign src_q   = regs[IX_SRC];
    assign dst_q   = regs[IX_DST];
    assign link_q  = regs[IX_LINK];
endmodule

// File: rtl/ll_loader_chk.sv
// Protocol and format checks for the descriptor loader, bound to its top.
module ll_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_done,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic [31:0] link_q,
    input logic        next_start,
    input logic        chan_done,
    input logic        link_err
);
    // R3: a pending request keeps its address until answered
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R3: descriptor reads are word aligned
    p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R2: completion is a single-cycle pulse caused by transfer-done
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |=> !chan_done);
    p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> ($past(xfer_done) && !mem_req));

    // R8: restart is a single-cycle pulse
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        next_start |=> !next_start);

    // R7: link register always in legal format
    p_link_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q[1:0] == 2'b00) && (link_q[31:22] == '0));

    // R9: an error never comes with a restart
    p_err_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_err) |-> !next_start);
endmodule

bind ll_desc_loader ll_loader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_done  (xfer_done),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .link_q     (link_q),
    .next_start (next_start),
    .chan_done  (chan_done),
    .link_err   (link_err)
);

// File: tb/tb_ll_desc_loader.sv
module tb_ll_desc_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_hi = 16'h2000;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        eng_cnt_we = 1'b0;
    logic [15:0] eng_cnt = '0;
    logic        xfer_done = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic        mem_rerr;
    logic [31:0] mem_rdata;
    logic [31:0] xcfg1_q, xcfg2_q, blk_q, src_q, dst_q, link_q;
    logic        next_start, chan_done, link_err, link_busy;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    logic [31:0] mem [256];
    logic [31:0] log_addr [16];
    int          nlog = 0;
    int          nstart = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    always #10 clk = ~clk;

    ll_desc_loader dut (
        .clk(clk), .rst_n(rst_n), .base_hi(base_hi),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .eng_cnt_we(eng_cnt_we), .eng_cnt(eng_cnt), .xfer_done(xfer_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rerr(mem_rerr), .mem_rdata(mem_rdata),
        .xcfg1_q(xcfg1_q), .xcfg2_q(xcfg2_q), .blk_q(blk_q),
        .src_q(src_q), .dst_q(dst_q), .link_q(link_q),
        .next_start(next_start), .chan_done(chan_done),
        .link_err(link_err), .link_busy(link_busy)
    );

    // Memory model: one-cycle response latency, logs each answered address.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            if (mem_req && !mem_rvalid) begin
                mem_rdata <= mem[mem_addr[9:2]];
                mem_rerr  <= err_en && (mem_addr == err_addr);
            end
            if (mem_req && mem_rvalid) begin
                if (nlog < 16) log_addr[nlog] <= mem_addr;
                nlog <= nlog + 1;
            end
            if (next_start) nstart <= nstart + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Pulse xfer_done for one edge; returns right after that edge's negedge.
    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 xcfg1", xcfg1_q, 0);
        check("R1 blk", blk_q, 0);
        check("R1 link", link_q, 0);
        check("R1 flags", {28'd0, mem_req, next_start, chan_done, link_err}, 0);
        check("R1 busy", {31'd0, link_busy}, 0);
    endtask

    task automatic t_format();
        cfg_write(5, 32'hFFFF_FFFF);
        check("R7 cfg write format", link_q, 32'h003F_FFFC);
        cfg_write(5, 32'h0);
    endtask

    task automatic t_terminal();
        int l0;
        cfg_write(0, 32'h0000_0011);
        l0 = nlog;
        pulse_done();
        check("R2 chan_done pulse", {31'd0, chan_done}, 1);
        check("R2 no busy", {31'd0, link_busy}, 0);
        @(negedge clk);
        check("R2 pulse one cycle", {31'd0, chan_done}, 0);
        settle(3);
        check("R2 no reads", 32'(nlog - l0), 0);
        check("R2 regs kept", xcfg1_q, 32'h0000_0011);
    endtask

    task automatic t_full();
        int l0, s0;
        for (int i = 0; i < 5; i++) mem[16+i] = {16'(i+1) * 16'h1111, 16'(i+1)};
        mem[21] = 32'h0;
        cfg_write(5, 32'h003F_0043);
        l0 = nlog; s0 = nstart;
        pulse_done();
        settle(16);
        check("R4 six words", 32'(nlog - l0), 6);
        for (int k = 0; k < 6; k++)
            check("R3 address sequence", log_addr[l0+k], 32'h2000_0040 + 32'(4*k));
        check("R4 xcfg1", xcfg1_q, 32'h1111_0001);
        check("R4 xcfg2", xcfg2_q, 32'h2222_0002);
        check("R4 blk", blk_q, 32'h3333_0003);
        check("R4 src", src_q, 32'h4444_0004);
        check("R4 dst", dst_q, 32'h5555_0005);
        check("R4 link", link_q, 32'h0);
        check("R8 one start", 32'(nstart - s0), 1);
        pulse_done();
        check("R8 loaded end of list", {31'd0, chan_done}, 1);
    endtask

    task automatic t_partial();
        int l0;
        mem[64] = 32'hCAFE_0040;
        mem[65] = 32'hFFC0_0203;
        cfg_write(5, 32'h0028_0100);
        l0 = nlog;
        pulse_done();
        settle(8);
        check("R4 two words", 32'(nlog - l0), 2);
        check("R3 first addr", log_addr[l0], 32'h2000_0100);
        check("R3 second addr", log_addr[l0+1], 32'h2000_0104);
        check("R4 src loaded", src_q, 32'hCAFE_0040);
        check("R7 loaded link format", link_q, 32'h0000_0200);
        check("R5 xcfg1 kept", xcfg1_q, 32'h1111_0001);
        check("R5 xcfg2 kept", xcfg2_q, 32'h2222_0002);
        check("R5 dst kept", dst_q, 32'h5555_0005);
        check("R5 blk kept", blk_q, 32'h3333_0003);
    endtask

    task automatic t_offset_only();
        int l0;
        l0 = nlog;
        pulse_done();
        check("R10 start next cycle", {31'd0, next_start}, 1);
        check("R10 no chan_done", {31'd0, chan_done}, 0);
        settle(3);
        check("R10 no reads", 32'(nlog - l0), 0);
    endtask

    task automatic t_restore();
        mem[192] = 32'h0;
        cfg_write(2, 32'hABCD_0123);
        @(negedge clk);
        eng_cnt_we = 1'b1; eng_cnt = 16'h0000;
        @(negedge clk);
        eng_cnt_we = 1'b0;
        check("R6 engine count applied", blk_q, 32'hABCD_0000);
        cfg_write(5, 32'h0020_0300);
        pulse_done();
        check("R6 count restored", blk_q, 32'hABCD_0123);
        settle(6);
        check("R6 link reloaded", link_q, 32'h0);
    endtask

    task automatic t_error();
        int s0;
        for (int i = 0; i < 5; i++) cfg_write(i, 32'h0000_00A0 + 32'(i));
        for (int i = 0; i < 6; i++) mem[96+i] = 32'h0000_00B0 + 32'(i);
        err_en = 1'b1; err_addr = 32'h2000_0188;
        cfg_write(5, 32'h003F_0180);
        s0 = nstart;
        pulse_done();
        settle(14);
        check("R9 xcfg1 before error", xcfg1_q, 32'h0000_00B0);
        check("R9 xcfg2 before error", xcfg2_q, 32'h0000_00B1);
        check("R9 blk not written", blk_q, 32'h0000_00A2);
        check("R9 src not written", src_q, 32'h0000_00A3);
        check("R9 dst not written", dst_q, 32'h0000_00A4);
        check("R9 link not written", link_q, 32'h003F_0180);
        check("R9 error flag", {31'd0, link_err}, 1);
        check("R9 no start", 32'(nstart - s0), 0);
        err_en = 1'b0;
        cfg_write(5, 32'h0);
        check("R9 flag cleared by write", {31'd0, link_err}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_format();
        t_terminal();
        t_full();
        t_partial();
        t_offset_only();
        t_restore();
        t_error();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule